// File: doc/BRIEF.md
# Hundredths Stopwatch Core

This block measures elapsed time to one hundredth of a second and keeps it as four BCD digits, read as SS.hh, from 00.00 up to 99.99. A fast system clock is divided down to a 100 Hz tick. Each tick advances the lowest digit while the watch is running. The digits are four cascaded decimal counters. A digit that passes 9 enables the next digit up for one cycle, and the whole count rolls from 99.99 back to 00.00.

Two raw push buttons control the watch: one clears it and one starts and stops it. Each button is synchronised to the clock and filtered by a shift-register debouncer that samples on the 100 Hz tick. An edge detector then turns each accepted press into a single one-cycle pulse. A two-state machine changes between stopped and running once per start/stop pulse. Clear zeroes the digits and leaves the run state as it is.

A scan counter presents one digit at a time on a shared seven-segment bus and a one-hot digit-select bus, both active-low. The decimal point is lit only while the seconds-units digit is selected. The count and the run state are also brought out as plain parallel outputs. This block has no data stream, so all of its pins are plain control and status signals with no valid/ready handshake.

Top module: `stopwatch_core`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `time_bcd` is 16'h0000 and `running` is 0.
- R2: While running, `time_bcd` read as a decimal number increases by exactly one for every 2*TICK_DIV clock cycles (one timebase tick).
- R3: Each nibble of `time_bcd` stays in 0..9. A digit at 9 goes to 0 when it advances and carries into the next nibble. Nibble [3:0] is hundredths, [7:4] is tenths, [11:8] is seconds units and [15:12] is tens of seconds. After 99.99 the count goes to 00.00.
- R4: A button takes effect only after its synchronised level has been 1 on DEB_LEN (4) consecutive ticks. A pulse that spans fewer ticks has no effect.
- R5: Each accepted press of `btn_startstop` toggles `running` exactly once. Holding the button down does not toggle it again.
- R6: While stopped, `time_bcd` does not change.
- R7: An accepted press of `btn_clear` sets `time_bcd` to 16'h0000 on the next edge, even when a tick falls in the same cycle. It leaves `running` unchanged.
- R8: Exactly one bit of `an_n` is 0 at any time. The selected position k advances 0,1,2,3,0,... every SCAN_DIV cycles, and position k shows nibble k of `time_bcd`.
- R9: `seg_n` is the active-low pattern of the selected digit, with bit 0 = segment a through bit 6 = segment g. The active-high codes for 0..9 are 3F,06,5B,4F,66,6D,7D,07,7F,6F. `dp_n` is 0 only while position 2 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_clear | input | 1 | Raw clear button, active high |
| btn_startstop | input | 1 | Raw start/stop button, active high |
| seg_n | output | 7 | Active-low segments g..a of the selected digit |
| dp_n | output | 1 | Active-low decimal point |
| an_n | output | 4 | Active-low one-hot digit select |
| time_bcd | output | 16 | Current count, four BCD digits |
| running | output | 1 | 1 while the watch counts |

## Verification
The assertions check, on every cycle:
- the one-hot digit select and the decimal point following position 2;
- the BCD range of every nibble;
- a count held while stopped;
- clear forcing zero on the next edge while keeping the run state;
- a single-cycle press pulse toggling the run state;
- the 99.99 wrap.

Only the bench scenarios can show the rest:
- that a tick comes every 2*TICK_DIV cycles and advances the count by exactly one;
- that a short glitch is rejected while a long hold toggles only once;
- that the segment patterns match the digits;
- that the scan moves to the next position after SCAN_DIV cycles.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int DIGITS   = 4;
  localparam int DP_POS   = 2;
  localparam int SEL_W    = $clog2(DIGITS);

  typedef enum logic {RUN_OFF = 1'b0, RUN_ON = 1'b1} run_state_t;

  // active-high segments, bit 0 = a .. bit 6 = g
  function automatic logic [6:0] seg_code(input logic [3:0] v);
    logic [6:0] s;
    case (v)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h40;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sw_timebase.sv
module sw_timebase #(
  parameter int TICK_DIV = 250000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;
  logic          half;
  logic          half_q;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // toggle flop on the divider carry: square wave of period 2*TICK_DIV
  always_ff @(posedge clk) begin
    if (rst) begin
      half   <= 1'b0;
      half_q <= 1'b0;
    end else begin
      if (wrap) half <= ~half;
      half_q <= half;
    end
  end

  assign tick = half & ~half_q;
endmodule

// File: rtl/sw_debounce.sv
module sw_debounce #(
  parameter int DEB_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic btn_raw,
  output logic press
);
  logic [1:0]         sync;
  logic [DEB_LEN-1:0] hist;
  logic               level;
  logic               level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= '0;
    end else begin
      sync <= {sync[0], btn_raw};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
    end else if (tick) begin
      hist <= {hist[DEB_LEN-2:0], sync[1]};
    end
  end

  assign level = &hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
    end else begin
      level_q <= level;
    end
  end

  assign press = level & ~level_q;
endmodule

// File: rtl/sw_bcd_digit.sv
module sw_bcd_digit #(
  parameter int MODULUS = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       enb,
  output logic [3:0] q,
  output logic       carry
);
  localparam logic [3:0] TOP = 4'(MODULUS - 1);

  assign carry = (q == TOP) & enb;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (enb) begin
      if (carry) q <= '0;
      else       q <= q + 4'd1;
    end
  end
endmodule

// File: rtl/sw_scan.sv
module sw_scan #(
  parameter int SCAN_DIV = 50000,
  parameter int POSITIONS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  output logic [$clog2(POSITIONS)-1:0] sel
);
  localparam int CW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SCAN_DIV - 1);
  localparam int PW = $clog2(POSITIONS);

  logic [CW-1:0] cnt;
  logic          step;

  assign step = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      sel <= '0;
    end else begin
      cnt <= step ? '0 : cnt + 1'b1;
      if (step) begin
        if (sel == PW'(POSITIONS - 1)) sel <= '0;
        else                           sel <= sel + 1'b1;
      end
    end
  end
endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
  import sw_pkg::*;
#(
  parameter int TICK_DIV = 250000,
  parameter int DEB_LEN  = 4,
  parameter int SCAN_DIV = 50000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        btn_clear,
  input  logic        btn_startstop,
  output logic [6:0]  seg_n,
  output logic        dp_n,
  output logic [3:0]  an_n,
  output logic [15:0] time_bcd,
  output logic        running
);
  logic             tick;
  logic             clr_press;
  logic             ss_press;
  logic             adv;
  run_state_t       state;
  logic [DIGITS:0]  chain;
  logic [SEL_W-1:0] sel;
  logic [3:0]       shown;

  sw_timebase #(.TICK_DIV(TICK_DIV)) i_tb (
    .clk(clk), .rst(rst), .tick(tick)
  );

  sw_debounce #(.DEB_LEN(DEB_LEN)) i_db_clr (
    .clk(clk), .rst(rst), .tick(tick), .btn_raw(btn_clear), .press(clr_press)
  );

  sw_debounce #(.DEB_LEN(DEB_LEN)) i_db_ss (
    .clk(clk), .rst(rst), .tick(tick), .btn_raw(btn_startstop), .press(ss_press)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RUN_OFF;
    end else if (ss_press) begin
      state <= (state == RUN_ON) ? RUN_OFF : RUN_ON;
    end
  end

  assign running  = (state == RUN_ON);
  assign adv      = tick & running;
  assign chain[0] = adv;

  generate
    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      sw_bcd_digit #(.MODULUS(10)) i_dig (
        .clk(clk), .rst(rst), .clr(clr_press), .enb(chain[d]),
        .q(time_bcd[4*d +: 4]), .carry(chain[d+1])
      );
    end
  endgenerate

  sw_scan #(.SCAN_DIV(SCAN_DIV), .POSITIONS(DIGITS)) i_scan (
    .clk(clk), .rst(rst), .sel(sel)
  );

  always_comb begin
    shown = 4'd0;
    for (int k = 0; k < DIGITS; k++) begin
      if (sel == SEL_W'(k)) shown = time_bcd[4*k +: 4];
    end
  end

  always_comb begin
    an_n = '1;
    an_n[sel] = 1'b0;
  end

  assign seg_n = ~seg_code(shown);
  assign dp_n  = (sel != SEL_W'(DP_POS));
endmodule

// File: rtl/sw_checker.sv
module sw_checker (
  input logic        clk,
  input logic        rst,
  input logic        adv,
  input logic        clr_press,
  input logic        ss_press,
  input logic        running,
  input logic [15:0] time_bcd,
  input logic [3:0]  an_n,
  input logic        dp_n
);
  p_onehot_sel_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(an_n) == 3);

  p_dp_pos_r9: assert property (@(posedge clk) disable iff (rst)
    dp_n == an_n[2]);

  p_bcd_range_r3: assert property (@(posedge clk) disable iff (rst)
    time_bcd[3:0] <= 4'd9 && time_bcd[7:4] <= 4'd9 &&
    time_bcd[11:8] <= 4'd9 && time_bcd[15:12] <= 4'd9);

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (adv && time_bcd == 16'h9999) |=> time_bcd == 16'h0000);

  p_hold_stopped_r6: assert property (@(posedge clk) disable iff (rst)
    (!running && !clr_press) |=> $stable(time_bcd));

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    clr_press |=> time_bcd == 16'h0000);

  p_clear_keeps_run_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_press && !ss_press) |=> $stable(running));

  p_press_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    ss_press |=> !ss_press);

  p_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    ss_press |=> running != $past(running));
endmodule

bind stopwatch_core sw_checker i_sw_checker (
  .clk(clk), .rst(rst), .adv(adv), .clr_press(clr_press), .ss_press(ss_press),
  .running(running), .time_bcd(time_bcd), .an_n(an_n), .dp_n(dp_n)
);

// File: tb/test_stopwatch_core.sv
module test_stopwatch_core;
  localparam int TICK_DIV = 2;
  localparam int SCAN_DIV = 5;
  localparam int TPER     = 2 * TICK_DIV;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        btn_clear = 1'b0;
  logic        btn_startstop = 1'b0;
  logic [6:0]  seg_n;
  logic        dp_n;
  logic [3:0]  an_n;
  logic [15:0] time_bcd;
  logic        running;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stopwatch_core #(.TICK_DIV(TICK_DIV), .DEB_LEN(4), .SCAN_DIV(SCAN_DIV)) i_stopwatch_core (
    .clk(clk), .rst(rst), .btn_clear(btn_clear), .btn_startstop(btn_startstop),
    .seg_n(seg_n), .dp_n(dp_n), .an_n(an_n), .time_bcd(time_bcd), .running(running)
  );

  // run lengths in ticks and the expected count advance for each
  localparam int NV = 6;
  localparam int RUN_TICKS [NV] = '{1, 9, 10, 91, 100, 900};
  localparam int EXP_DELTA [NV] = '{1, 9, 10, 91, 100, 900};

  function automatic int to_int(input logic [15:0] b);
    return b[15:12]*1000 + b[11:8]*100 + b[7:4]*10 + b[3:0];
  endfunction

  function automatic logic [6:0] exp_seg(input logic [3:0] v);
    logic [6:0] s;
    case (v)
      4'd0: s = 7'h3F; 4'd1: s = 7'h06; 4'd2: s = 7'h5B; 4'd3: s = 7'h4F;
      4'd4: s = 7'h66; 4'd5: s = 7'h6D; 4'd6: s = 7'h7D; 4'd7: s = 7'h07;
      4'd8: s = 7'h7F; default: s = 7'h6F;
    endcase
    return ~s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input bit which_clear, input int hold);
    if (which_clear) btn_clear = 1'b1; else btn_startstop = 1'b1;
    wait_clk(hold);
    btn_clear = 1'b0;
    btn_startstop = 1'b0;
    wait_clk(12 * TPER);
  endtask

  task automatic check_scan();
    int prev_k = -1;
    int since = 0;
    int steps = 0;
    for (int c = 0; c < 6 * SCAN_DIV; c++) begin
      int k = -1;
      int lows = 0;
      @(negedge clk);
      for (int j = 0; j < 4; j++) if (!an_n[j]) begin k = j; lows++; end
      check("R8 one select low", lows, 1);
      if (k >= 0) begin
        check("R9 segments", int'(seg_n), int'(exp_seg(time_bcd[4*k +: 4])));
        check("R9 decimal point", int'(dp_n), (k == 2) ? 0 : 1);
      end
      if (prev_k >= 0 && k != prev_k) begin
        check("R8 next position", k, (prev_k + 1) % 4);
        if (steps > 0) check("R8 dwell cycles", since, SCAN_DIV);
        steps++;
        since = 0;
      end
      since++;
      prev_k = k;
    end
  endtask

  initial begin
    wait_clk(190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v0;
    wait_clk(3);
    check("R1 time in reset", int'(time_bcd), 0);
    check("R1 stopped in reset", int'(running), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 time after reset", int'(time_bcd), 0);
    check("R1 stopped after reset", int'(running), 0);

    // short glitch spanning at most two ticks
    press(1'b0, 2 * TPER);
    check("R4 glitch ignored", int'(running), 0);
    check("R6 stopped holds zero", int'(time_bcd), 0);

    // long hold toggles once
    press(1'b0, 12 * TPER);
    check("R5 hold toggles once", int'(running), 1);

    for (int i = 0; i < NV; i++) begin
      v0 = to_int(time_bcd);
      wait_clk(RUN_TICKS[i] * TPER);
      check("R2 ticks advance count", (to_int(time_bcd) - v0 + 10000) % 10000, EXP_DELTA[i]);
    end

    press(1'b0, 12 * TPER);
    check("R5 second press stops", int'(running), 0);
    v0 = to_int(time_bcd);
    wait_clk(50 * TPER);
    check("R6 stopped holds count", to_int(time_bcd), v0);

    check_scan();

    press(1'b1, 12 * TPER);
    check("R7 clear while stopped", int'(time_bcd), 0);
    check("R7 clear keeps stopped", int'(running), 0);

    press(1'b0, 12 * TPER);
    check("R5 restart", int'(running), 1);
    wait_clk(37 * TPER);
    press(1'b1, 12 * TPER);
    check("R7 clear keeps running", int'(running), 1);
    check("R7 count restarted from zero", int'(to_int(time_bcd) <= 30), 1);

    // run up to 99.99 and watch the wrap
    begin
      int guard = 0;
      while (time_bcd != 16'h9999 && guard < 60000) begin
        @(negedge clk);
        guard++;
      end
    end
    check("R3 reached 99.99", int'(time_bcd), 16'h9999);
    wait_clk(TPER);
    check("R3 wrap to 00.00", int'(time_bcd), 0);
    wait_clk(10 * TPER);
    check("R3 count after wrap", to_int(time_bcd), 10);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule